// File: doc/BRIEF.md
# Multiplexed Local Bus Byte-Burst Write Sequencer

This block sequences write bursts from an internal requester onto an external 8-bit device that sits on a multiplexed address/data local bus. A request carries a base address, a length of 1 to 32 bytes and up to 32 bytes of data. The sequencer runs a single address phase, in which the full address is driven on the shared lanes under a latch-enable strobe. It then issues one data beat per byte. During each beat the most significant byte lane carries the data byte, the remaining lanes keep showing the address, and a separate group of low-order address lines steps through the byte offsets within a 32-byte block.

Each beat is paced by an internally generated transfer acknowledge, which comes from two timing fields captured when the request is accepted. The wait field sets how many cycles pass between the start of the beat and the acknowledge. The hold field sets how many extra cycles chip select stays asserted after the acknowledge. The lanes change only at the end of an acknowledge cycle. The requester gets a one-cycle done pulse after the last acknowledge. A debug enable mirrors the acknowledge onto a data-valid output.

The controller has five states. `ST_IDLE` moves to `ST_ADDR` when a request is valid. `ST_ADDR` moves to `ST_WAIT`, or straight to `ST_ACK` if the wait field is zero. `ST_WAIT` counts down and then moves to `ST_ACK`. `ST_ACK` always moves to `ST_GAP`. `ST_GAP` counts down the hold cycles and then moves to `ST_WAIT` or `ST_ACK` for the next byte, or to `ST_IDLE` after the final byte.

Top module: `lbus_burst_wr`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `bus_ale`=0, `bus_cs_n`=1, `bus_we_n`=1, `done`=0, `bus_dval`=0, `bus_ad`=0, `bus_alow`=0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle the address phase runs for exactly one cycle, with `bus_ale`=1, `bus_ad` equal to the request address, and `bus_cs_n` and `bus_we_n` both 1. While the block is busy, `req_ready` is 0 and `req_valid` has no effect on the burst in progress.
- R3: The latch strobe and the internal acknowledge are never high in the same cycle. With debug enabled, the acknowledge is observed on `bus_dval`.
- R4: Each beat holds `bus_cs_n`=0 and `bus_we_n`=0 for wait+1 cycles, the last of which is the acknowledge cycle. It then holds `bus_cs_n`=0 and `bus_we_n`=1 for hold+1 cycles. `bus_we_n` is never 0 while `bus_cs_n` is 1.
- R5: In beat k, `bus_ad[31:24]` carries request byte k, where byte k is `req_data[8k+7:8k]`, and `bus_ad[23:0]` carries the request address bits [23:0].
- R6: In beat k, `bus_alow` equals (request address[4:0] + k) mod 32.
- R7: Within a burst, `bus_ad` and `bus_alow` change only at the clock edge that ends an acknowledge cycle. After the final acknowledge they hold the last byte until the block returns to idle.
- R8: The number of beats is `req_len_m1`+1, so a field value of 0 gives 1 byte and 31 gives 32 bytes.
- R9: `done` is high for exactly one cycle, namely the cycle after the final acknowledge. `req_ready` returns to 1 once the hold cycles after that acknowledge have ended.
- R10: `bus_dval` is 1 exactly in acknowledge cycles while `cfg_dbg_en` is 1, and is 0 at all other times.
- R11: `cfg_wait` and `cfg_hold` are captured when a request is accepted. Changing them during a burst does not alter that burst's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 32 | Burst base address |
| req_len_m1 | input | 5 | Byte count minus one |
| req_data | input | 256 | Burst bytes, byte k at bits 8k+7:8k |
| cfg_wait | input | 4 | Cycles from beat start to acknowledge (0-15) |
| cfg_hold | input | 2 | Extra chip-select cycles after acknowledge (0-3) |
| cfg_dbg_en | input | 1 | Mirror the acknowledge on bus_dval |
| done | output | 1 | One-cycle burst completion pulse |
| bus_ale | output | 1 | Address latch enable strobe |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_ad | output | 32 | Multiplexed address/data lanes |
| bus_alow | output | 5 | Low-order byte address lines |
| bus_dval | output | 1 | Debug mirror of the internal acknowledge |

## Verification
The assertions assume that every input is a known value at each clock edge. They also assume the requester holds address, length and data stable through the edge where the request is accepted, because the burst is built only from what is captured at that edge. The timing fields are narrow enough that every value they can hold is legal. The stimulus therefore draws wait and hold values over their full ranges and changes them freely during bursts. Request data is changed only while the block is busy, which is when `req_ready` is 0, and the busy-period pokes keep `req_valid` high with a different address to show that such a request is not taken.

// File: rtl/lbus_burst_pkg.sv
package lbus_burst_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_ACK,
        ST_GAP
    } bus_state_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/lbus_phase_timer.sv
module lbus_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign zero = (cnt_q == '0);

    // R4: the sequencer must never count a phase below zero
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt_q != '0));

endmodule

// File: rtl/lbus_byte_pump.sv
module lbus_byte_pump #(
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 32,
    parameter int BYTE_W    = 8,
    localparam int IDX_W    = $clog2(MAX_BYTES),
    localparam int DATA_W   = MAX_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [IDX_W-1:0]  load_len_m1,
    input  logic              step,
    output logic [BYTE_W-1:0] cur_byte,
    output logic [ADDR_W-1:0] base_addr,
    output logic [IDX_W-1:0]  low_addr,
    output logic              last_beat
);

    logic [DATA_W-1:0] shreg_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  len_q;

    assign last_beat = (idx_q == len_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            addr_q  <= '0;
            idx_q   <= '0;
            len_q   <= '0;
        end else if (load) begin
            shreg_q <= load_data;
            addr_q  <= load_addr;
            idx_q   <= '0;
            len_q   <= load_len_m1;
        end else if (step && !last_beat) begin
            shreg_q <= {{BYTE_W{1'b0}}, shreg_q[DATA_W-1:BYTE_W]};
            idx_q   <= idx_q + IDX_W'(1);
        end
    end

    assign cur_byte  = shreg_q[BYTE_W-1:0];
    assign base_addr = addr_q;
    assign low_addr  = addr_q[IDX_W-1:0] + idx_q;

    // R8: the beat index never passes the requested length
    p_idx_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= len_q);

    // R7: the byte only moves on a step
    p_step_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(shreg_q));

endmodule

// File: rtl/lbus_burst_wr.sv
module lbus_burst_wr
    import lbus_burst_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int MAX_BYTES = 32,
    parameter int WAIT_W    = 4,
    parameter int HOLD_W    = 2,
    localparam int IDX_W    = $clog2(MAX_BYTES),
    localparam int DATA_W   = MAX_BYTES * BYTE_W,
    localparam int TMR_W    = (WAIT_W > HOLD_W) ? WAIT_W : HOLD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IDX_W-1:0]  req_len_m1,
    input  logic [DATA_W-1:0] req_data,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [HOLD_W-1:0] cfg_hold,
    input  logic              cfg_dbg_en,
    output logic              done,
    output logic              bus_ale,
    output logic              bus_cs_n,
    output logic              bus_we_n,
    output logic [ADDR_W-1:0] bus_ad,
    output logic [IDX_W-1:0]  bus_alow,
    output logic              bus_dval
);

    bus_state_e state_q, state_d;

    logic [WAIT_W-1:0] wait_q;
    logic [HOLD_W-1:0] hold_q;
    logic              fin_q;
    logic              done_q;
    logic              accept;
    logic              ta;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_dec;
    logic              tmr_zero;
    logic [BYTE_W-1:0] cur_byte;
    logic [ADDR_W-1:0] base_addr;
    logic [IDX_W-1:0]  low_addr;
    logic              last_beat;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign ta     = (state_q == ST_ACK);

    lbus_phase_timer #(.CNT_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .dec      (tmr_dec),
        .zero     (tmr_zero)
    );

    lbus_byte_pump #(
        .ADDR_W    (ADDR_W),
        .MAX_BYTES (MAX_BYTES),
        .BYTE_W    (BYTE_W)
    ) u_pump (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .load_addr   (req_addr),
        .load_data   (req_data),
        .load_len_m1 (req_len_m1),
        .step        (ta),
        .cur_byte    (cur_byte),
        .base_addr   (base_addr),
        .low_addr    (low_addr),
        .last_beat   (last_beat)
    );

    // state register and captured burst controls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wait_q  <= '0;
            hold_q  <= '0;
            fin_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= ta && last_beat;
            if (accept) begin
                wait_q <= cfg_wait;
                hold_q <= cfg_hold;
                fin_q  <= 1'b0;
            end else if (ta && last_beat) begin
                fin_q  <= 1'b1;
            end
        end
    end

    // next state and phase timer control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(wait_q) - TMR_W'(1);
        tmr_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (wait_q == '0) begin
                    state_d = ST_ACK;
                end else begin
                    state_d  = ST_WAIT;
                    tmr_load = 1'b1;
                end
            end
            ST_WAIT: begin
                if (tmr_zero) state_d = ST_ACK;
                else          tmr_dec = 1'b1;
            end
            ST_ACK: begin
                state_d  = ST_GAP;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(hold_q);
            end
            ST_GAP: begin
                if (!tmr_zero) begin
                    tmr_dec = 1'b1;
                end else if (fin_q) begin
                    state_d = ST_IDLE;
                end else if (wait_q == '0) begin
                    state_d = ST_ACK;
                end else begin
                    state_d  = ST_WAIT;
                    tmr_load = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // bus outputs decoded from state
    always_comb begin
        req_ready = 1'b0;
        bus_ale   = 1'b0;
        bus_cs_n  = 1'b1;
        bus_we_n  = 1'b1;
        bus_ad    = '0;
        bus_alow  = '0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_ADDR: begin
                bus_ale  = 1'b1;
                bus_ad   = base_addr;
                bus_alow = low_addr;
            end
            ST_WAIT, ST_ACK: begin
                bus_cs_n = 1'b0;
                bus_we_n = 1'b0;
                bus_ad   = {cur_byte, base_addr[ADDR_W-BYTE_W-1:0]};
                bus_alow = low_addr;
            end
            ST_GAP: begin
                bus_cs_n = 1'b0;
                bus_ad   = {cur_byte, base_addr[ADDR_W-BYTE_W-1:0]};
                bus_alow = low_addr;
            end
            default: ;
        endcase
    end

    assign done     = done_q;
    assign bus_dval = ta && cfg_dbg_en;

    // R2: an accepted request opens with the address phase carrying its address
    p_accept_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (bus_ale && bus_ad == $past(req_addr)));

    // R2: the latch strobe lasts one cycle, with control lines quiet
    p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale);
    p_ale_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |-> (bus_cs_n && bus_we_n));

    // R3: strobe and acknowledge exclusive
    p_ale_ta_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_ale && ta));

    // R4: write enable only under chip select, released after acknowledge
    p_we_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we_n |-> !bus_cs_n);
    p_we_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ta |=> (bus_we_n && !bus_cs_n));

    // R7: lanes frozen inside a beat unless the previous cycle acknowledged
    p_lane_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && !$past(bus_cs_n) && !$past(ta))
            |-> ($stable(bus_ad) && $stable(bus_alow)));

    // R9: done only follows an acknowledge, and lasts one cycle
    p_done_after_ta_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(ta));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/lbus_burst_wr_test.sv
module lbus_burst_wr_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [4:0]   req_len_m1 = '0;
    logic [255:0] req_data = '0;
    logic [3:0]   cfg_wait = '0;
    logic [1:0]   cfg_hold = '0;
    logic         cfg_dbg_en = 1'b0;
    logic         done;
    logic         bus_ale;
    logic         bus_cs_n;
    logic         bus_we_n;
    logic [31:0]  bus_ad;
    logic [4:0]   bus_alow;
    logic         bus_dval;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    lbus_burst_wr uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len_m1(req_len_m1), .req_data(req_data),
        .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_dbg_en(cfg_dbg_en),
        .done(done), .bus_ale(bus_ale), .bus_cs_n(bus_cs_n), .bus_we_n(bus_we_n),
        .bus_ad(bus_ad), .bus_alow(bus_alow), .bus_dval(bus_dval)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_lanes(input logic [31:0] a, input logic [255:0] d, input int k);
        return {d[8*k +: 8], a[23:0]};
    endfunction

    function automatic logic [4:0] exp_low(input logic [31:0] a, input int k);
        return 5'(a[4:0] + 5'(k));
    endfunction

    task automatic chk_idle(input string tag);
        chk({tag, " ready"}, 32'(req_ready), 32'd1);
        chk({tag, " ale"},   32'(bus_ale),   32'd0);
        chk({tag, " cs_n"},  32'(bus_cs_n),  32'd1);
        chk({tag, " we_n"},  32'(bus_we_n),  32'd1);
        chk({tag, " done"},  32'(done),      32'd0);
        chk({tag, " dval"},  32'(bus_dval),  32'd0);
        chk({tag, " ad"},    bus_ad,         32'd0);
        chk({tag, " alow"},  32'(bus_alow),  32'd0);
    endtask

    // one burst traced cycle by cycle against the requirements
    task automatic run_burst(input logic [31:0] a, input logic [4:0] lm1,
                             input logic [255:0] d, input logic [3:0] w,
                             input logic [1:0] h, input bit dbg,
                             input bit poke_busy, input bit poke_cfg);
        int nb;
        nb = int'(lm1) + 1;
        @(negedge clk);
        chk("R9 ready before request", 32'(req_ready), 32'd1);
        req_valid  = 1'b1;
        req_addr   = a;
        req_len_m1 = lm1;
        req_data   = d;
        cfg_wait   = w;
        cfg_hold   = h;
        cfg_dbg_en = dbg;
        @(negedge clk);
        chk("R2 ale", 32'(bus_ale), 32'd1);
        chk("R2 addr", bus_ad, a);
        chk("R2 cs_n quiet", 32'(bus_cs_n), 32'd1);
        chk("R2 we_n quiet", 32'(bus_we_n), 32'd1);
        chk("R3 no dval in ale", 32'(bus_dval), 32'd0);
        chk("R2 ready low", 32'(req_ready), 32'd0);
        if (poke_busy) begin
            req_addr = ~a;
            req_data = ~d;
            req_len_m1 = ~lm1;
        end else begin
            req_valid = 1'b0;
        end
        if (poke_cfg) begin
            cfg_wait = ~w;
            cfg_hold = ~h;
        end
        for (int k = 0; k < nb; k++) begin
            for (int c = 0; c <= int'(w); c++) begin
                @(negedge clk);
                chk("R4 cs_n beat", 32'(bus_cs_n), 32'd0);
                chk("R4 we_n beat", 32'(bus_we_n), 32'd0);
                chk("R3 ale off", 32'(bus_ale), 32'd0);
                chk("R10 dval", 32'(bus_dval), 32'((c == int'(w)) && dbg));
                chk("R5 lanes", bus_ad, exp_lanes(a, d, k));
                chk("R6 alow", 32'(bus_alow), 32'(exp_low(a, k)));
                chk("R9 done low", 32'(done), 32'd0);
            end
            for (int g = 0; g <= int'(h); g++) begin
                int nk;
                nk = (k == nb - 1) ? k : k + 1;
                @(negedge clk);
                chk("R4 cs_n gap", 32'(bus_cs_n), 32'd0);
                chk("R4 we_n gap", 32'(bus_we_n), 32'd1);
                chk("R10 dval gap", 32'(bus_dval), 32'd0);
                chk("R7 lanes gap", bus_ad, exp_lanes(a, d, nk));
                chk("R7 alow gap", 32'(bus_alow), 32'(exp_low(a, nk)));
                chk("R9 done", 32'(done), 32'((k == nb - 1) && (g == 0)));
                chk("R8 ready busy", 32'(req_ready), 32'd0);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk_idle("R9 R8 back idle");
    endtask

    function automatic logic [255:0] rand_data();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom();
        return v;
    endfunction

    initial begin
        logic [255:0] ramp;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 32; i++) ramp[8*i +: 8] = 8'(i);
        repeat (3) @(negedge clk);
        chk_idle("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 after release");
        // full 32-byte burst, fastest timing, debug on
        run_burst(32'h0000_5420, 5'd31, ramp, 4'd0, 2'd0, 1'b1, 1'b0, 1'b0);
        // single byte, slowest timing
        run_burst(32'hA5C3_0011, 5'd0, rand_data(), 4'd15, 2'd3, 1'b1, 1'b0, 1'b0);
        // low lines wrap past 0x1F, debug off
        run_burst(32'h1234_567C, 5'd7, rand_data(), 4'd2, 2'd1, 1'b0, 1'b0, 1'b0);
        // R2: request held during burst ignored; R11: config changed mid-burst
        run_burst(32'h0BAD_F00D, 5'd4, rand_data(), 4'd3, 2'd2, 1'b1, 1'b1, 1'b1);
        run_burst(32'h7700_0040, 5'd2, rand_data(), 4'd0, 2'd0, 1'b0, 1'b1, 1'b1);
        for (int n = 0; n < 40; n++) begin
            run_burst($urandom(), 5'($urandom()), rand_data(), 4'($urandom()),
                      2'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R9 act=running exp=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule